// File: doc/BRIEF.md
# Dual-Buffer Pixel Sample Writer

This block takes 16-bit video samples from a sampling front end and stores them as pixels in a shared on-chip memory. Software describes two target regions, called slots 0 and 1. Each slot has a byte base address and a pixel count. The block fills one armed slot completely before it moves to the other. After a slot completes, the block prefers the opposite slot. If that slot is not armed, it falls back to whichever slot is armed. Two consecutive pixels are packed into one 32-bit memory word.

With averaging enabled, every four accepted samples produce one pixel. A completed slot raises its ready flag, and a level interrupt follows those flags. The flag stays up until software acknowledges the slot or arms it again. A sample that arrives while neither slot is armed is dropped. Each drop is counted in a saturating counter and latches an overrun flag. The counter and the flag are cleared together by a clear strobe.

Top module: `pix_pair_writer`

## Requirements
- R1: An arm request with a nonzero `cfg_addr[1:0]`, an odd count, a zero count, or a target slot that is still armed is rejected. `cfg_err` is then 1 and the slot stays unarmed. An accepted request sets `cfg_err` to 0.
- R2: The first pixel of a pair goes into `mem_wdata[15:0]` and the second into `mem_wdata[31:16]`. One write happens per pair, at word address `cfg_addr/4 + pair index`. The write appears on the cycle after the second pixel is accepted.
- R3: When `avg_en` is 1, four accepted samples form one pixel. The pixel is bits [17:2] of their 18-bit sum.
- R4: When `avg_en` is 0, every accepted sample is one pixel, unchanged.
- R5: A slot's `buf_ready` bit rises together with the write of its last word. It holds until `buf_ack` for that slot or a new arm of that slot. `irq` is 1 whenever any `buf_ready` bit is 1.
- R6: After a slot completes, the next sample goes to the other slot if it is armed, otherwise to the one that is armed.
- R7: A sample arriving with no slot armed causes no memory write. It increments `drop_cnt` and sets `overrun`.
- R8: `drop_cnt` saturates at its all-ones value. `drop_clr` clears both `drop_cnt` and `overrun`.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Arm request strobe |
| cfg_sel | input | 1 | Slot to arm |
| cfg_addr | input | AW | Byte base address of the slot |
| cfg_count | input | CW | Pixel count of the slot |
| buf_ack | input | 2 | Per-slot ready acknowledge |
| avg_en | input | 1 | Four-sample averaging enable |
| drop_clr | input | 1 | Clears the drop counter and the overrun flag |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample value |
| mem_we | output | 1 | Memory word write enable |
| mem_waddr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Packed pixel pair |
| buf_ready | output | 2 | Per-slot completion flags |
| irq | output | 1 | Level interrupt |
| overrun | output | 1 | Sticky drop indicator |
| drop_cnt | output | DW | Saturating dropped-sample count |
| cfg_err | output | 1 | Result of the last arm request |

## Verification
The bench walks averaging groups that include all-ones samples, because dropping the top sum bits would return 0x3FFF instead of 0xFFFF. It also uses groups whose remainder must be truncated.

The ping-pong test arms both slots while the preference points at slot 1. A design that always restarts at slot 0 writes the words to the wrong addresses.

Re-arming a slot that is still armed must be rejected, and re-arming a completed slot must clear its ready flag. Rejected arms are checked by sending a sample afterwards, which must be dropped. A burst longer than the counter range checks that the counter saturates instead of wrapping.

// File: rtl/pix_pair_writer.sv
module pix_pair_writer #(
  parameter int AW = 12,
  parameter int CW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    buf_ack,
  input  logic          avg_en,
  input  logic          drop_clr,
  input  logic          smp_valid,
  input  logic [15:0]   smp_data,
  output logic          mem_we,
  output logic [AW-3:0] mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic [1:0]    buf_ready,
  output logic          irq,
  output logic          overrun,
  output logic [DW-1:0] drop_cnt,
  output logic          cfg_err
);
  localparam int WW = AW - 2;
  localparam int PW = CW - 1;

  logic [1:0]    armed, ready_q;
  logic [WW-1:0] base_q [2];
  logic [PW-1:0] pairs_q [2];
  logic          cur, half;
  logic [PW-1:0] woff;
  logic [15:0]   lo;
  logic [17:0]   acc;
  logic [1:0]    ph;
  logic          we_q, ovr_q, err_q;
  logic [WW-1:0] waddr_q;
  logic [31:0]   wdata_q;
  logic [DW-1:0] drop_q;

  logic          act, take, drop, pix_v, wr, last, bad, arm_ok;
  logic [17:0]   sum;
  logic [15:0]   pix;

  assign act    = armed[cur] ? cur : ~cur;
  assign take   = smp_valid && (armed != 2'b00);
  assign drop   = smp_valid && (armed == 2'b00);
  assign sum    = acc + 18'(smp_data);
  assign pix_v  = take && (!avg_en || ph == 2'd3);
  assign pix    = avg_en ? sum[17:2] : smp_data;
  assign wr     = pix_v && half;
  assign last   = wr && (woff == pairs_q[act] - PW'(1));
  assign bad    = (cfg_addr[1:0] != 2'b00) || cfg_count[0] ||
                  (cfg_count == '0) || armed[cfg_sel];
  assign arm_ok = cfg_wr && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= '0; ready_q <= '0; cur <= 1'b0; half <= 1'b0;
      woff <= '0; lo <= '0; acc <= '0; ph <= '0;
      we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0;
      ovr_q <= 1'b0; err_q <= 1'b0; drop_q <= '0;
      for (int i = 0; i < 2; i++) begin
        base_q[i]  <= '0;
        pairs_q[i] <= '0;
      end
    end else begin
      we_q <= wr;
      if (wr) begin
        waddr_q <= base_q[act] + WW'(woff);
        wdata_q <= {pix, lo};
        woff    <= last ? '0 : woff + PW'(1);
      end
      if (pix_v) begin
        if (!half) lo <= pix;
        half <= ~half;
      end
      if (take) cur <= last ? ~act : act;
      if (!avg_en) begin
        acc <= '0;
        ph  <= '0;
      end else if (take) begin
        acc <= (ph == 2'd3) ? '0 : sum;
        ph  <= ph + 2'd1;
      end
      for (int i = 0; i < 2; i++) begin
        if (buf_ack[i]) ready_q[i] <= 1'b0;
        if (arm_ok && cfg_sel == 1'(i)) begin
          armed[i]   <= 1'b1;
          ready_q[i] <= 1'b0;
          base_q[i]  <= cfg_addr[AW-1:2];
          pairs_q[i] <= cfg_count[CW-1:1];
        end
        if (last && act == 1'(i)) begin
          armed[i]   <= 1'b0;
          ready_q[i] <= 1'b1;
        end
      end
      if (cfg_wr) err_q <= bad;
      if (drop_clr) begin
        drop_q <= '0;
        ovr_q  <= 1'b0;
      end else if (drop) begin
        ovr_q <= 1'b1;
        if (drop_q != '1) drop_q <= drop_q + DW'(1);
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign buf_ready = ready_q;
  assign irq       = |ready_q;
  assign overrun   = ovr_q;
  assign drop_cnt  = drop_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/pix_pair_writer_chk.sv
module pix_pair_writer_chk #(
  parameter int AW = 12,
  parameter int CW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_sel,
  input logic [AW-1:0] cfg_addr,
  input logic [CW-1:0] cfg_count,
  input logic [1:0]    buf_ack,
  input logic          drop_clr,
  input logic          smp_valid,
  input logic          mem_we,
  input logic [1:0]    buf_ready,
  input logic          irq,
  input logic [DW-1:0] drop_cnt,
  input logic          cfg_err,
  input logic [1:0]    armed
);
  a_r1_misaligned_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr[1:0] != 2'b00 |=> cfg_err);
  a_r1_odd_count_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_count[0] |=> cfg_err);
  a_r7_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && armed == 2'b00 |=> !mem_we);
  a_r5_ready0_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ready[0]) |-> mem_we);
  a_r5_ready1_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ready[1]) |-> mem_we);
  a_r5_ready0_holds: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready[0] && !buf_ack[0] && !(cfg_wr && !cfg_sel) |=> buf_ready[0]);
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready != 2'b00 |-> irq);
  a_r8_drop_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt == '1 && !drop_clr |=> drop_cnt == '1);
  a_r8_drop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    drop_clr |=> drop_cnt == '0);
endmodule

bind pix_pair_writer pix_pair_writer_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_addr(cfg_addr), .cfg_count(cfg_count), .buf_ack(buf_ack),
  .drop_clr(drop_clr), .smp_valid(smp_valid), .mem_we(mem_we),
  .buf_ready(buf_ready), .irq(irq), .drop_cnt(drop_cnt),
  .cfg_err(cfg_err), .armed(armed)
);

// File: tb/pix_pair_writer_bench.sv
`timescale 1ns/1ps
module pix_pair_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [9:0]  cfg_count = '0;
  logic [1:0]  buf_ack = '0;
  logic        avg_en = 1'b0, drop_clr = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        mem_we, irq, overrun, cfg_err;
  logic [9:0]  mem_waddr;
  logic [31:0] mem_wdata;
  logic [1:0]  buf_ready;
  logic [7:0]  drop_cnt;

  int total = 0, bad = 0, wr_n = 0;
  logic [9:0]  log_a [64];
  logic [31:0] log_d [64];

  // {s0, s1, s2, s3, expected averaged pixel}
  localparam logic [79:0] AVG_TBL [6] = '{
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0002},
    {16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000, 16'h0000, 16'h4000},
    {16'h0007, 16'h0007, 16'h0007, 16'h0006, 16'h0006}
  };

  pix_pair_writer u_pix_pair_writer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .buf_ack(buf_ack),
    .avg_en(avg_en), .drop_clr(drop_clr), .smp_valid(smp_valid),
    .smp_data(smp_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .buf_ready(buf_ready), .irq(irq),
    .overrun(overrun), .drop_cnt(drop_cnt), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (mem_we) begin
      log_a[wr_n % 64] = mem_waddr;
      log_d[wr_n % 64] = mem_wdata;
      wr_n = wr_n + 1;
    end
  end

  initial begin
    #1000000;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic arm(input logic s, input logic [11:0] a, input logic [9:0] n);
    cfg_wr = 1'b1; cfg_sel = s; cfg_addr = a; cfg_count = n;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ack(input logic [1:0] m);
    buf_ack = m;
    @(negedge clk);
    buf_ack = '0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 mem_we", {31'd0, mem_we}, 0);
    chk("R9 ready/irq", {29'd0, buf_ready, irq}, 0);
    chk("R9 drop/ovr/err", {22'd0, drop_cnt, overrun, cfg_err}, 0);

    // R3 averaging table: group under test, then a group averaging to 4
    avg_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      w0 = wr_n;
      arm(1'b0, 12'h040, 10'd2);
      send(AVG_TBL[i][79:64]); send(AVG_TBL[i][63:48]);
      send(AVG_TBL[i][47:32]); send(AVG_TBL[i][31:16]);
      repeat (4) send(16'h0004);
      @(negedge clk);
      chk("R3 write count", wr_n - w0, 1);
      chk("R3 averaged word", log_d[(wr_n - 1) % 64], {16'h0004, AVG_TBL[i][15:0]});
      chk("R2 address", {22'd0, log_a[(wr_n - 1) % 64]}, 32'h10);
      chk("R5 ready0", {30'd0, buf_ready}, 2'b01);
      ack(2'b01);
    end

    // R4 pass-through and R2 packing order
    avg_en = 1'b0;
    w0 = wr_n;
    arm(1'b0, 12'h080, 10'd4);
    send(16'h1111); send(16'h2222); send(16'h3333); send(16'h4444);
    @(negedge clk);
    chk("R4 write count", wr_n - w0, 2);
    chk("R4 word0", log_d[w0 % 64], 32'h2222_1111);
    chk("R2 addr0", {22'd0, log_a[w0 % 64]}, 32'h20);
    chk("R4 word1", log_d[(w0 + 1) % 64], 32'h4444_3333);
    chk("R2 addr1", {22'd0, log_a[(w0 + 1) % 64]}, 32'h21);
    repeat (5) @(negedge clk);
    chk("R5 ready holds", {29'd0, buf_ready, irq}, 3'b011);
    ack(2'b01);
    chk("R5 ack clears", {29'd0, buf_ready, irq}, 0);

    // R6 ping-pong: preference now points at slot 1
    w0 = wr_n;
    arm(1'b0, 12'h100, 10'd2);
    arm(1'b1, 12'h200, 10'd2);
    send(16'hA001); send(16'hA002); send(16'hA003); send(16'hA004);
    @(negedge clk);
    chk("R6 first to slot1", {22'd0, log_a[w0 % 64]}, 32'h80);
    chk("R6 first data", log_d[w0 % 64], 32'hA002_A001);
    chk("R6 second to slot0", {22'd0, log_a[(w0 + 1) % 64]}, 32'h40);
    chk("R6 both ready", {29'd0, buf_ready, irq}, 3'b111);
    arm(1'b0, 12'h140, 10'd2);
    chk("R5 rearm clears ready", {30'd0, buf_ready}, 2'b10);
    ack(2'b10);
    w0 = wr_n;
    send(16'hB001); send(16'hB002);
    @(negedge clk);
    chk("R6 fallback to slot0", {22'd0, log_a[w0 % 64]}, 32'h50);
    ack(2'b01);

    // R1 rejected arms leave the slot unarmed
    arm(1'b1, 12'h203, 10'd2);
    chk("R1 misaligned err", {31'd0, cfg_err}, 1);
    arm(1'b1, 12'h200, 10'd3);
    chk("R1 odd count err", {31'd0, cfg_err}, 1);
    arm(1'b1, 12'h200, 10'd0);
    chk("R1 zero count err", {31'd0, cfg_err}, 1);
    w0 = wr_n;
    send(16'hC001);
    @(negedge clk);
    chk("R1 not armed -> drop", {24'd0, drop_cnt}, 1);
    chk("R7 overrun set", {31'd0, overrun}, 1);
    arm(1'b1, 12'h200, 10'd2);
    chk("R1 valid arm", {31'd0, cfg_err}, 0);
    arm(1'b1, 12'h300, 10'd2);
    chk("R1 already armed err", {31'd0, cfg_err}, 1);
    send(16'hC002); send(16'hC003);
    @(negedge clk);
    chk("R1 original descriptor kept", {22'd0, log_a[(wr_n - 1) % 64]}, 32'h80);
    ack(2'b10);

    // R8 clear, then R7 drops with nothing armed
    drop_clr = 1'b1; @(negedge clk); drop_clr = 1'b0;
    chk("R8 clear", {23'd0, drop_cnt, overrun}, 0);
    w0 = wr_n;
    send(16'h0001); send(16'h0002); send(16'h0003);
    @(negedge clk);
    chk("R7 drop count", {24'd0, drop_cnt}, 3);
    chk("R7 no writes", wr_n - w0, 0);

    // R8 saturation
    for (int k = 0; k < 300; k++) send(16'(k));
    @(negedge clk);
    chk("R8 saturates", {24'd0, drop_cnt}, 32'hFF);
    drop_clr = 1'b1; @(negedge clk); drop_clr = 1'b0;
    chk("R8 clear after sat", {23'd0, drop_cnt, overrun}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule